// File: doc/BRIEF.md
# Three-Operand Parallel-Prefix Adder

This block adds three unsigned operands of the same width in one combinational pass and returns their exact sum, two bits wider than an operand. A row of per-bit 3:2 compressors first turns the three operands into a partial-sum vector and a carry vector. The carry vector, moved up one place, and the partial-sum vector then feed a two-operand prefix carry tree of logarithmic depth. A closing XOR row forms the result. No carry ripples from one operand pair into the next, as it would in two chained adders.

The prefix tree is picked at build time by an integer parameter. Three trees are available: a minimum-depth full tree, a sparse tree that resolves odd positions and patches even ones, and a divide-and-conquer tree with fewer cells and higher fan-out. Any other parameter value stops elaboration with an error. The block has no clock and no state. It sits inside whatever pipeline stage the surrounding logic places it in.

Top module: `tri_prefix_add`

## Requirements
- R1: `total` equals `opnd_a + opnd_b + opnd_c` as unsigned numbers for every input combination, and is WIDTH+2 bits wide.
- R2: Each bit position compresses its three input bits to a partial sum (XOR of the three) and a carry (majority of the three). The partial-sum vector plus twice the carry vector equals the three-operand sum, so the same bit k set in all three operands gives 3·2^k.
- R3: TOPOLOGY selects the prefix tree: 0 is the minimum-depth full tree, 1 is the odd-position sparse tree with one extra fix-up level, and 2 is the divide-and-conquer tree. All three give identical outputs for identical inputs.
- R4: WIDTH is a parameter of at least 2. The block is correct at widths 4, 16 and 32.
- R5: The carry into bit 0 is zero. All-zero operands give 0. A single bit set in one operand, with the others zero, gives that operand's value.
- R6: The two top result bits carry the final group carry and the top compressor carry. `total[WIDTH+1]` is 1 exactly when the sum is at least 2^(WIDTH+1). All-ones on every operand gives 3·(2^WIDTH−1). The pattern (2^WIDTH−1) + (2^WIDTH−1) + 2 gives exactly 2^(WIDTH+1).
- R7: A carry resolves across the full width. (2^WIDTH−1) + 1 + 0 gives 2^WIDTH with only bit WIDTH set. Each prefix tree's group generate equals the ripple carry of its two inputs.
- R8: The block is purely combinational. `total` reflects new operands without any clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_a | input | WIDTH | First unsigned operand |
| opnd_b | input | WIDTH | Second unsigned operand |
| opnd_c | input | WIDTH | Third unsigned operand |
| total | output | WIDTH+2 | Exact unsigned sum of the three operands |

## Verification
The assertions assume operands hold known two-state values. They also assume that the prefix tree only ever sees generate and propagate bits that are never both 1 at the same position. The compressor-to-half-adder split guarantees this, and one assertion checks it. The bench drives only fully specified operand values and changes them only between checks. Every tree therefore receives legal generate/propagate pairs: from an exhaustive 4-bit sweep, from the named corner patterns and from random wide vectors.

// File: rtl/tpa_pkg.sv
`timescale 1ns/1ps
package tpa_pkg;
  // Prefix tree selection codes
  localparam int TOPO_KS = 0;  // minimum-depth full tree
  localparam int TOPO_HC = 1;  // odd positions full, even fixed at the end
  localparam int TOPO_LF = 2;  // divide-and-conquer, fewer cells
endpackage

// File: rtl/tpa_pcell.sv
`timescale 1ns/1ps
module tpa_pcell (
  input  logic hi_g,
  input  logic hi_p,
  input  logic lo_g,
  input  logic lo_p,
  output logic g_o,
  output logic p_o
);
  // associative group combine: upper span absorbs lower span
  assign g_o = hi_g | (hi_p & lo_g);
  assign p_o = hi_p & lo_p;
endmodule

// File: rtl/tpa_csa.sv
`timescale 1ns/1ps
module tpa_csa #(
  parameter int W = 16
) (
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  input  logic [W-1:0] op_c,
  output logic [W-1:0] psum,
  output logic [W-1:0] pcar
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign psum[i] = op_a[i] ^ op_b[i] ^ op_c[i];
    assign pcar[i] = (op_a[i] & op_b[i]) | (op_b[i] & op_c[i]) | (op_a[i] & op_c[i]);
  end

  always_comb begin
    // R2
    compress_weight_chk: assert (({2'b00, psum} + {1'b0, pcar, 1'b0}) ==
                                 ({2'b00, op_a} + {2'b00, op_b} + {2'b00, op_c}))
      else $error("compressor vectors lose weight");
  end
endmodule

// File: rtl/tpa_prefix.sv
`timescale 1ns/1ps
module tpa_prefix
  import tpa_pkg::*;
#(
  parameter int W    = 16,
  parameter int TOPO = TOPO_KS
) (
  input  logic [W-1:0] g_in,
  input  logic [W-1:0] p_in,
  output logic [W-1:0] grp
);
  localparam int LVL = (W > 1) ? $clog2(W) : 1;

  logic [W-1:0] p_fin;

  if (TOPO == TOPO_KS) begin : g_ks
    logic [LVL:0][W-1:0] gk, pk;
    assign gk[0] = g_in;
    assign pk[0] = p_in;
    for (genvar l = 1; l <= LVL; l++) begin : g_lv
      localparam int D = 1 << (l - 1);
      for (genvar i = 0; i < W; i++) begin : g_pos
        if (i >= D) begin : g_cell
          tpa_pcell u_c (.hi_g(gk[l-1][i]), .hi_p(pk[l-1][i]),
                         .lo_g(gk[l-1][i-D]), .lo_p(pk[l-1][i-D]),
                         .g_o(gk[l][i]), .p_o(pk[l][i]));
        end else begin : g_pass
          assign gk[l][i] = gk[l-1][i];
          assign pk[l][i] = pk[l-1][i];
        end
      end
    end
    assign grp   = gk[LVL];
    assign p_fin = pk[LVL];
  end else if (TOPO == TOPO_LF) begin : g_lf
    logic [LVL:0][W-1:0] gk, pk;
    assign gk[0] = g_in;
    assign pk[0] = p_in;
    for (genvar l = 1; l <= LVL; l++) begin : g_lv
      for (genvar i = 0; i < W; i++) begin : g_pos
        localparam int J = ((i >> (l - 1)) << (l - 1)) - 1;
        if (((i >> (l - 1)) & 1) == 1) begin : g_cell
          tpa_pcell u_c (.hi_g(gk[l-1][i]), .hi_p(pk[l-1][i]),
                         .lo_g(gk[l-1][J]), .lo_p(pk[l-1][J]),
                         .g_o(gk[l][i]), .p_o(pk[l][i]));
        end else begin : g_pass
          assign gk[l][i] = gk[l-1][i];
          assign pk[l][i] = pk[l-1][i];
        end
      end
    end
    assign grp   = gk[LVL];
    assign p_fin = pk[LVL];
  end else if (TOPO == TOPO_HC) begin : g_hc
    logic [LVL+1:0][W-1:0] gk, pk;
    assign gk[0] = g_in;
    assign pk[0] = p_in;
    for (genvar l = 1; l <= LVL + 1; l++) begin : g_lv
      localparam int D = (l == 1 || l == LVL + 1) ? 1 : (1 << (l - 1));
      for (genvar i = 0; i < W; i++) begin : g_pos
        localparam bit ODD  = (i % 2) == 1;
        localparam bit LIVE = (l == LVL + 1) ? (!ODD && i >= 2) : (ODD && i >= D);
        if (LIVE) begin : g_cell
          tpa_pcell u_c (.hi_g(gk[l-1][i]), .hi_p(pk[l-1][i]),
                         .lo_g(gk[l-1][i-D]), .lo_p(pk[l-1][i-D]),
                         .g_o(gk[l][i]), .p_o(pk[l][i]));
        end else begin : g_pass
          assign gk[l][i] = gk[l-1][i];
          assign pk[l][i] = pk[l-1][i];
        end
      end
    end
    assign grp   = gk[LVL+1];
    assign p_fin = pk[LVL+1];
  end else begin : g_bad
    $error("tpa_prefix: unsupported TOPO value %0d", TOPO);
  end

  // checker: arithmetic reference for the group signals
  logic [W:0]   ref_sum;
  logic [W:0]   ref_cin;
  logic [W-1:0] zero_m;
  logic [W-1:0] ref_and;
  always_comb begin
    ref_sum = {1'b0, g_in | p_in} + {1'b0, g_in};
    ref_cin = ref_sum ^ {1'b0, p_in};
    zero_m  = ~p_in;
    ref_and = (zero_m & (~zero_m + 1'b1)) - 1'b1;
    // R7
    gp_exclusive_chk: assert ((g_in & p_in) == '0)
      else $error("generate and propagate overlap");
    // R7
    grp_carry_chk: assert (grp == ref_cin[W:1])
      else $error("group generate differs from ripple carry");
    // R3
    grp_prop_chk: assert (p_fin == ref_and)
      else $error("group propagate differs from prefix AND");
  end
endmodule

// File: rtl/tri_prefix_add.sv
`timescale 1ns/1ps
module tri_prefix_add
  import tpa_pkg::*;
#(
  parameter int WIDTH    = 16,
  parameter int TOPOLOGY = TOPO_KS
) (
  input  logic [WIDTH-1:0] opnd_a,
  input  logic [WIDTH-1:0] opnd_b,
  input  logic [WIDTH-1:0] opnd_c,
  output logic [WIDTH+1:0] total
);
  localparam int TW = WIDTH + 2;

  if (WIDTH < 2) begin : g_bad_width
    $error("tri_prefix_add: WIDTH must be at least 2");
  end
  if (TOPOLOGY != TOPO_KS && TOPOLOGY != TOPO_HC && TOPOLOGY != TOPO_LF) begin : g_bad_topo
    $error("tri_prefix_add: unsupported TOPOLOGY %0d", TOPOLOGY);
  end

  logic [WIDTH-1:0] psum, pcar, car_sh, gen, prop, grp;
  logic             top_car, grp_out;

  tpa_csa #(.W(WIDTH)) u_csa (
    .op_a(opnd_a), .op_b(opnd_b), .op_c(opnd_c),
    .psum(psum), .pcar(pcar)
  );

  // compressed carries weigh one place higher; nothing enters bit 0
  assign car_sh  = {pcar[WIDTH-2:0], 1'b0};
  assign top_car = pcar[WIDTH-1];
  assign gen     = psum & car_sh;
  assign prop    = psum ^ car_sh;

  tpa_prefix #(.W(WIDTH), .TOPO(TOPOLOGY)) u_pfx (
    .g_in(gen), .p_in(prop), .grp(grp)
  );

  assign grp_out = grp[WIDTH-1];

  always_comb begin
    total[0]           = prop[0];
    total[WIDTH-1:1]   = prop[WIDTH-1:1] ^ grp[WIDTH-2:0];
    total[WIDTH]       = grp_out ^ top_car;
    total[WIDTH+1]     = grp_out & top_car;
  end

  logic [TW-1:0] ref_total;
  always_comb begin
    ref_total = TW'(opnd_a) + TW'(opnd_b) + TW'(opnd_c);
    // R1
    sum_exact_chk: assert (total == ref_total)
      else $error("sum differs from operand total");
    // R6
    top_bits_chk: assert (total[WIDTH+1] == (ref_total >= (TW'(1) << (WIDTH + 1))))
      else $error("top result bit wrong");
  end
endmodule

// File: tb/tri_prefix_add_tb.sv
`timescale 1ns/1ps
module tri_prefix_add_tb;
  import tpa_pkg::*;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic [31:0] a32 = '0, b32 = '0, c32 = '0;
  logic [15:0] a16, b16, c16;
  logic [3:0]  a4 = '0, b4 = '0, c4 = '0;
  assign a16 = a32[15:0];
  assign b16 = b32[15:0];
  assign c16 = c32[15:0];

  logic [33:0] s_ks32, s_hc32, s_lf32;
  logic [17:0] s_ks16, s_hc16, s_lf16;
  logic [5:0]  s_ks4, s_hc4, s_lf4;

  tri_prefix_add #(.WIDTH(16), .TOPOLOGY(TOPO_KS)) u_dut (.opnd_a(a16), .opnd_b(b16), .opnd_c(c16), .total(s_ks16));
  tri_prefix_add #(.WIDTH(16), .TOPOLOGY(TOPO_HC)) u_hc16 (.opnd_a(a16), .opnd_b(b16), .opnd_c(c16), .total(s_hc16));
  tri_prefix_add #(.WIDTH(16), .TOPOLOGY(TOPO_LF)) u_lf16 (.opnd_a(a16), .opnd_b(b16), .opnd_c(c16), .total(s_lf16));
  tri_prefix_add #(.WIDTH(32), .TOPOLOGY(TOPO_KS)) u_ks32 (.opnd_a(a32), .opnd_b(b32), .opnd_c(c32), .total(s_ks32));
  tri_prefix_add #(.WIDTH(32), .TOPOLOGY(TOPO_HC)) u_hc32 (.opnd_a(a32), .opnd_b(b32), .opnd_c(c32), .total(s_hc32));
  tri_prefix_add #(.WIDTH(32), .TOPOLOGY(TOPO_LF)) u_lf32 (.opnd_a(a32), .opnd_b(b32), .opnd_c(c32), .total(s_lf32));
  tri_prefix_add #(.WIDTH(4),  .TOPOLOGY(TOPO_KS)) u_ks4  (.opnd_a(a4), .opnd_b(b4), .opnd_c(c4), .total(s_ks4));
  tri_prefix_add #(.WIDTH(4),  .TOPOLOGY(TOPO_HC)) u_hc4  (.opnd_a(a4), .opnd_b(b4), .opnd_c(c4), .total(s_hc4));
  tri_prefix_add #(.WIDTH(4),  .TOPOLOGY(TOPO_LF)) u_lf4  (.opnd_a(a4), .opnd_b(b4), .opnd_c(c4), .total(s_lf4));

  int total_n = 0;
  int bad_n   = 0;
  int cyc     = 0;

  task automatic chk(input string tag, input string what, input logic [33:0] got, input logic [33:0] exp);
    total_n++;
    if (got !== exp) begin
      bad_n++;
      $display("FAIL %s %s got=%h exp=%h", tag, what, got, exp);
    end
  endtask

  // drive both wide widths; sample 1 ns later with no clock edge between
  task automatic apply_wide(input logic [31:0] x, input logic [31:0] y, input logic [31:0] z, input string tag);
    logic [33:0] e32, e16;
    @(posedge clk);
    a32 = x; b32 = y; c32 = z;
    #1;
    e32 = {2'b00, x} + {2'b00, y} + {2'b00, z};
    e16 = {18'd0, x[15:0]} + {18'd0, y[15:0]} + {18'd0, z[15:0]};
    chk(tag,  "ks32", s_ks32, e32);
    chk("R3", "hc32", s_hc32, e32);
    chk("R3", "lf32", s_lf32, e32);
    chk(tag,  "ks16", {16'd0, s_ks16}, e16);
    chk("R3", "hc16", {16'd0, s_hc16}, e16);
    chk("R3", "lf16", {16'd0, s_lf16}, e16);
  endtask

  task automatic apply_narrow(input logic [3:0] x, input logic [3:0] y, input logic [3:0] z);
    logic [33:0] e4;
    @(posedge clk);
    a4 = x; b4 = y; c4 = z;
    #1;
    e4 = {30'd0, x} + {30'd0, y} + {30'd0, z};
    chk("R4", "ks4", {28'd0, s_ks4}, e4);
    chk("R4", "hc4", {28'd0, s_hc4}, e4);
    chk("R4", "lf4", {28'd0, s_lf4}, e4);
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      total_n++;
      bad_n++;
      $display("FAIL watchdog expired got=%0d exp<150000 cycles", cyc);
      $display("  test done: total=%0d bad=%0d", total_n, bad_n);
      $finish;
    end
  end

  initial begin
    // R5: all zero operands give zero
    apply_wide(32'h0, 32'h0, 32'h0, "R5");
    // R6: all ones on every operand
    apply_wide(32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R6");
    // R6: lands exactly on 2^(W+1)
    apply_wide(32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h2, "R6");
    // R7: full-width carry chain
    apply_wide(32'hFFFF_FFFF, 32'h1, 32'h0, "R7");
    apply_wide(32'hAAAA_AAAA, 32'h5555_5555, 32'h1, "R7");
    apply_wide(32'h0, 32'hFFFF_FFFF, 32'h1, "R7");
    // R8: output follows a fresh input change without an edge
    apply_wide(32'h1234_5678, 32'h9ABC_DEF0, 32'h0F0F_0F0F, "R8");
    for (int k = 0; k < 32; k++) begin
      // R5: single bit on one operand
      apply_wide(32'h1 << k, 32'h0, 32'h0, "R5");
      apply_wide(32'h0, 32'h1 << k, 32'h0, "R5");
      apply_wide(32'h0, 32'h0, 32'h1 << k, "R5");
      // R2: same bit in all three gives 3*2^k
      apply_wide(32'h1 << k, 32'h1 << k, 32'h1 << k, "R2");
    end
    // R4: exhaustive sweep at width 4, all three trees
    for (int x = 0; x < 16; x++)
      for (int y = 0; y < 16; y++)
        for (int z = 0; z < 16; z++)
          apply_narrow(4'(x), 4'(y), 4'(z));
    // R1: random vectors at widths 16 and 32
    for (int n = 0; n < 10000; n++)
      apply_wide($urandom, $urandom, $urandom, "R1");
    $display("  test done: total=%0d bad=%0d", total_n, bad_n);
    $finish;
  end
endmodule